// File: doc/BRIEF.md
# SVGA Line Readout with Pixel-Repeat Stretch

The block runs the raster timing of an 800x600, 60 Hz display from a 40 MHz pixel clock. It produces positive-polarity horizontal and vertical sync and a data-enable that marks where picture pixels are shown. Inside the active area there is a smaller picture window. Within that window the block pulls 16-bit YCbCr words from an external line buffer. The fetch strobe is `buf_rd`, and the buffer answers one clock later on `buf_vld` / `buf_data`.

To widen the picture, the block repeats one pixel in every ten. At each such position it shows the last fetched word again and does not fetch a new one, so fewer stored samples fill the output line. At two fixed positions of the per-line read count, the block gives a one-clock refill request to an external frame-memory controller.

Every timing value can be changed through a parameter: porches, sync widths, window bounds, request points and the repeat period. A small raster therefore exercises the same logic as the full-size default.

Top module: `svga_line_reader`

## Requirements
- R1: While `rst_n` is low, `hsync`, `vsync`, `de`, `refill_req` and `buf_rd` are 0 and `pix` equals the black word `BLACK` (default 16'h1080: Y=0x10 in bits 15:8, chroma 0x80 in bits 7:0).
- R2: `hsync` is high for exactly H_SYNC clocks. It rises once every H_ACTIVE+H_FP+H_SYNC+H_BP clocks, H_ACTIVE+H_FP clocks after the start of a line.
- R3: `vsync` is high for exactly V_SYNC whole lines, once per frame, starting at line V_ACTIVE+V_FP, and changes only at a line boundary.
- R4: `de` is high exactly where the horizontal count lies strictly between WIN_H_LO and WIN_H_HI, the line count lies strictly between WIN_V_LO and WIN_V_HI, and the position is inside the active area. Vertical blanking therefore masks any part of the window that extends past the last active line.
- R5: `buf_rd` is asserted only for window positions. In each windowed line it is asserted exactly once for every window position that is not a repeat position.
- R6: Counting window positions from 0 at the left of each line, a position k with k mod DUP_PERIOD = DUP_PERIOD-1 shows the same word as position k-1 and fetches nothing.
- R7: All other window positions show the buffer words in the order in which they were delivered, with no word lost or duplicated.
- R8: `refill_req` is a one-clock pulse, high exactly at window positions REQ_A and REQ_B, so it fires twice in every windowed line.
- R9: Whenever `de` is low, `pix` equals `BLACK`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (40 MHz for the default raster) |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_rd | output | 1 | Fetch strobe toward the line buffer |
| buf_vld | input | 1 | Line buffer word is valid (one clock after `buf_rd`) |
| buf_data | input | PIX_W | Word returned by the line buffer |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |
| de | output | 1 | Picture pixel is being shown |
| pix | output | PIX_W | Pixel word, black outside `de` |
| refill_req | output | 1 | One-clock request to the frame-memory controller |

## Verification
The conditions that are hardest to reach from the ports are a whole frame boundary and the vertical window running past the last active line. Proving that the active-area gate and the window test work together needs full frames, which is far too many clocks at the default raster. The bench therefore instantiates the block with a shrunken raster whose vertical window deliberately overhangs vertical blanking, and runs three complete frames. A scoreboard replays the fetched words against the repeat pattern at every shown position. Relative distances between sync edges and `de` edges confirm where the window sits.

// File: rtl/svga_rd_pkg.sv
package svga_rd_pkg;

  localparam int unsigned CNT_W = 12;
  typedef logic [CNT_W-1:0] tcnt_t;

  // control bits travelling down the output pipeline
  typedef struct packed {
    logic de;
    logic hs;
    logic vs;
    logic dup;
    logic req;
  } ctrl_t;

  // strict open-interval test: lo < x < hi
  function automatic logic f_in_open(tcnt_t x, tcnt_t lo, tcnt_t hi);
    return (x > lo) && (x < hi);
  endfunction

  // half-open interval test: beg <= x < fin
  function automatic logic f_in_span(tcnt_t x, tcnt_t beg, tcnt_t fin);
    return (x >= beg) && (x < fin);
  endfunction

endpackage

// File: rtl/svga_tmg_gen.sv
module svga_tmg_gen
  import svga_rd_pkg::*;
#(
  parameter int unsigned H_ACTIVE = 800,
  parameter int unsigned H_FP     = 40,
  parameter int unsigned H_SYNC   = 128,
  parameter int unsigned H_BP     = 88,
  parameter int unsigned V_ACTIVE = 600,
  parameter int unsigned V_FP     = 1,
  parameter int unsigned V_SYNC   = 4,
  parameter int unsigned V_BP     = 23
) (
  input  logic  clk,
  input  logic  rst_n,
  output tcnt_t h_cnt,
  output tcnt_t v_cnt,
  output logic  line_end,
  output logic  active,
  output logic  hs,
  output logic  vs
);

  localparam int unsigned H_TOTAL = H_ACTIVE + H_FP + H_SYNC + H_BP;
  localparam int unsigned V_TOTAL = V_ACTIVE + V_FP + V_SYNC + V_BP;
  localparam tcnt_t H_LAST  = tcnt_t'(H_TOTAL - 1);
  localparam tcnt_t V_LAST  = tcnt_t'(V_TOTAL - 1);
  localparam tcnt_t H_ACT   = tcnt_t'(H_ACTIVE);
  localparam tcnt_t V_ACT   = tcnt_t'(V_ACTIVE);
  localparam tcnt_t HS_BEG  = tcnt_t'(H_ACTIVE + H_FP);
  localparam tcnt_t HS_END  = tcnt_t'(H_ACTIVE + H_FP + H_SYNC);
  localparam tcnt_t VS_BEG  = tcnt_t'(V_ACTIVE + V_FP);
  localparam tcnt_t VS_END  = tcnt_t'(V_ACTIVE + V_FP + V_SYNC);

  tcnt_t h_q, v_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h_q <= '0;
      v_q <= '0;
    end else if (h_q == H_LAST) begin
      h_q <= '0;
      v_q <= (v_q == V_LAST) ? '0 : v_q + 1'b1;
    end else begin
      h_q <= h_q + 1'b1;
    end
  end

  assign h_cnt    = h_q;
  assign v_cnt    = v_q;
  assign line_end = (h_q == H_LAST);
  assign active   = (h_q < H_ACT) && (v_q < V_ACT);
  assign hs       = f_in_span(h_q, HS_BEG, HS_END);
  assign vs       = f_in_span(v_q, VS_BEG, VS_END);

endmodule

// File: rtl/svga_rd_ctrl.sv
module svga_rd_ctrl
  import svga_rd_pkg::*;
#(
  parameter int unsigned WIN_H_LO   = 39,
  parameter int unsigned WIN_H_HI   = 788,
  parameter int unsigned WIN_V_LO   = 19,
  parameter int unsigned WIN_V_HI   = 604,
  parameter int unsigned REQ_A      = 100,
  parameter int unsigned REQ_B      = 500,
  parameter int unsigned DUP_PERIOD = 10
) (
  input  logic  clk,
  input  logic  rst_n,
  input  tcnt_t h_cnt,
  input  tcnt_t v_cnt,
  input  logic  line_end,
  input  logic  active,
  output logic  win,
  output logic  dup,
  output logic  pop,
  output logic  req,
  output tcnt_t rd_cnt
);

  localparam tcnt_t WHL  = tcnt_t'(WIN_H_LO);
  localparam tcnt_t WHH  = tcnt_t'(WIN_H_HI);
  localparam tcnt_t WVL  = tcnt_t'(WIN_V_LO);
  localparam tcnt_t WVH  = tcnt_t'(WIN_V_HI);
  localparam tcnt_t RQA  = tcnt_t'(REQ_A);
  localparam tcnt_t RQB  = tcnt_t'(REQ_B);

  tcnt_t cnt_q;

  // window: open interval on both axes, gated by the active area (R4)
  assign win = active && f_in_open(h_cnt, WHL, WHH) && f_in_open(v_cnt, WVL, WVH);

  // per-line read position, cleared at every line end
  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (line_end) cnt_q <= '0;
    else if (win)      cnt_q <= cnt_q + 1'b1;
  end

  assign rd_cnt = cnt_q;

  // repeat-phase counter, present only when repeating is configured (R6)
  generate
    if (DUP_PERIOD > 1) begin : g_dup
      localparam int unsigned PH_W = $clog2(DUP_PERIOD);
      localparam logic [PH_W-1:0] PH_LAST = PH_W'(DUP_PERIOD - 1);
      logic [PH_W-1:0] ph_q;

      always_ff @(posedge clk) begin
        if (!rst_n)        ph_q <= '0;
        else if (line_end) ph_q <= '0;
        else if (win)      ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      end

      assign dup = win && (ph_q == PH_LAST);
    end else begin : g_nodup
      assign dup = 1'b0;
    end
  endgenerate

  assign pop = win && !dup;
  assign req = win && ((cnt_q == RQA) || (cnt_q == RQB));

endmodule

// File: rtl/svga_px_out.sv
module svga_px_out
  import svga_rd_pkg::*;
#(
  parameter int unsigned    PIX_W = 16,
  parameter logic [PIX_W-1:0] BLACK = 16'h1080
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrl_t            ctrl_in,
  input  logic             buf_vld,
  input  logic [PIX_W-1:0] buf_data,
  output ctrl_t            ctrl_out,
  output logic [PIX_W-1:0] pix
);

  ctrl_t            s1_q, s2_q;
  logic [PIX_W-1:0] last_q, pix_q;

  // stage 1 waits for the buffer answer, stage 2 registers the pixel
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_q   <= '0;
      s2_q   <= '0;
      last_q <= BLACK;
      pix_q  <= BLACK;
    end else begin
      s1_q <= ctrl_in;
      s2_q <= s1_q;
      if (buf_vld) last_q <= buf_data;
      if (!s1_q.de)     pix_q <= BLACK;
      else if (buf_vld) pix_q <= buf_data;
      else              pix_q <= last_q;
    end
  end

  assign ctrl_out = s2_q;
  assign pix      = pix_q;

endmodule

// File: rtl/svga_line_reader.sv
module svga_line_reader
  import svga_rd_pkg::*;
#(
  parameter int unsigned H_ACTIVE   = 800,
  parameter int unsigned H_FP       = 40,
  parameter int unsigned H_SYNC     = 128,
  parameter int unsigned H_BP       = 88,
  parameter int unsigned V_ACTIVE   = 600,
  parameter int unsigned V_FP       = 1,
  parameter int unsigned V_SYNC     = 4,
  parameter int unsigned V_BP       = 23,
  parameter int unsigned WIN_H_LO   = 39,
  parameter int unsigned WIN_H_HI   = 788,
  parameter int unsigned WIN_V_LO   = 19,
  parameter int unsigned WIN_V_HI   = 604,
  parameter int unsigned REQ_A      = 100,
  parameter int unsigned REQ_B      = 500,
  parameter int unsigned DUP_PERIOD = 10,
  parameter int unsigned PIX_W      = 16,
  parameter logic [PIX_W-1:0] BLACK = 16'h1080
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             buf_rd,
  input  logic             buf_vld,
  input  logic [PIX_W-1:0] buf_data,
  output logic             hsync,
  output logic             vsync,
  output logic             de,
  output logic [PIX_W-1:0] pix,
  output logic             refill_req
);

  tcnt_t h_cnt, v_cnt, rd_cnt;
  logic  ln_end, act, hs_c, vs_c;
  logic  rd_win, rd_dup, rd_pop, rd_req;
  ctrl_t ctl_c, ctl_o;
  logic  out_dup;

  svga_tmg_gen #(
    .H_ACTIVE(H_ACTIVE), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_ACTIVE(V_ACTIVE), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP)
  ) u_tmg (
    .clk(clk), .rst_n(rst_n),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .line_end(ln_end),
    .active(act), .hs(hs_c), .vs(vs_c)
  );

  svga_rd_ctrl #(
    .WIN_H_LO(WIN_H_LO), .WIN_H_HI(WIN_H_HI),
    .WIN_V_LO(WIN_V_LO), .WIN_V_HI(WIN_V_HI),
    .REQ_A(REQ_A), .REQ_B(REQ_B), .DUP_PERIOD(DUP_PERIOD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .h_cnt(h_cnt), .v_cnt(v_cnt), .line_end(ln_end), .active(act),
    .win(rd_win), .dup(rd_dup), .pop(rd_pop), .req(rd_req), .rd_cnt(rd_cnt)
  );

  assign ctl_c = '{de: rd_win, hs: hs_c, vs: vs_c, dup: rd_dup, req: rd_req};

  svga_px_out #(.PIX_W(PIX_W), .BLACK(BLACK)) u_out (
    .clk(clk), .rst_n(rst_n),
    .ctrl_in(ctl_c), .buf_vld(buf_vld), .buf_data(buf_data),
    .ctrl_out(ctl_o), .pix(pix)
  );

  assign buf_rd     = rd_pop;
  assign hsync      = ctl_o.hs;
  assign vsync      = ctl_o.vs;
  assign de         = ctl_o.de;
  assign refill_req = ctl_o.req;
  assign out_dup    = ctl_o.dup;

endmodule

// File: rtl/svga_line_reader_chk.sv
module svga_line_reader_chk #(
  parameter int unsigned      H_SYNC = 128,
  parameter int unsigned      PIX_W  = 16,
  parameter logic [PIX_W-1:0] BLACK  = 16'h1080
) (
  input logic             clk,
  input logic             rst_n,
  input logic             buf_rd,
  input logic             win,
  input logic             dup,
  input logic             line_end,
  input logic             vs_c,
  input logic             hsync,
  input logic             de,
  input logic             out_dup,
  input logic             refill_req,
  input logic [PIX_W-1:0] pix
);

  localparam logic [15:0] HS_LEN = 16'(H_SYNC);
  logic [15:0] hs_run;

  always_ff @(posedge clk) begin
    if (!rst_n || !hsync) hs_run <= '0;
    else                  hs_run <= hs_run + 1'b1;
  end

  p_hsync_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hsync) |-> hs_run == HS_LEN);

  p_vsync_on_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vs_c) |-> $past(line_end));

  p_pop_in_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
    buf_rd |-> win);

  p_no_pop_on_dup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dup |-> !buf_rd);

  p_dup_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_dup && de) |-> pix == $past(pix));

  p_req_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |=> !refill_req);

  p_req_in_de_r8: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req |-> de);

  p_black_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> pix == BLACK);

endmodule

bind svga_line_reader svga_line_reader_chk #(
  .H_SYNC(H_SYNC), .PIX_W(PIX_W), .BLACK(BLACK)
) u_chk (
  .clk(clk), .rst_n(rst_n), .buf_rd(buf_rd), .win(rd_win), .dup(rd_dup),
  .line_end(ln_end), .vs_c(vs_c), .hsync(hsync), .de(de),
  .out_dup(out_dup), .refill_req(refill_req), .pix(pix)
);

// File: tb/svga_line_reader_tb.sv
module svga_line_reader_tb;

  // shrunken raster: 100 clocks per line, 36 lines per frame
  localparam int HA = 80, HFP = 4, HSW = 8, HBP = 8;
  localparam int VA = 30, VFP = 1, VSW = 2, VBP = 3;
  localparam int HT = HA + HFP + HSW + HBP;
  localparam int VT = VA + VFP + VSW + VBP;
  localparam int WHL = 3, WHH = 76, WVL = 2, WVH = 33;
  localparam int RQA = 10, RQB = 50, DUPP = 10;
  localparam logic [15:0] BLK = 16'h1080;

  localparam int WIN_LEN   = WHH - WHL - 1;                 // 72
  localparam int POPS_LINE = WIN_LEN - WIN_LEN / DUPP;      // 65
  localparam int DE_LINES  = VA - WVL - 1;                  // 27 (window overhangs blanking)
  localparam int HS_TO_DE  = HT - (HA + HFP) + WHL + 1;     // 20
  localparam int VS_TO_DE  = (VT - (VA + VFP) + WVL + 1) * HT + WHL + 1; // 804

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        buf_rd, buf_vld, hsync, vsync, de, refill_req;
  logic [15:0] buf_data, pix;

  always #10 clk = ~clk;   // 50 MHz

  svga_line_reader #(
    .H_ACTIVE(HA), .H_FP(HFP), .H_SYNC(HSW), .H_BP(HBP),
    .V_ACTIVE(VA), .V_FP(VFP), .V_SYNC(VSW), .V_BP(VBP),
    .WIN_H_LO(WHL), .WIN_H_HI(WHH), .WIN_V_LO(WVL), .WIN_V_HI(WVH),
    .REQ_A(RQA), .REQ_B(RQB), .DUP_PERIOD(DUPP), .PIX_W(16), .BLACK(BLK)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_rd(buf_rd), .buf_vld(buf_vld),
    .buf_data(buf_data), .hsync(hsync), .vsync(vsync), .de(de),
    .pix(pix), .refill_req(refill_req)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [15:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // driver: line-buffer model, answers one clock after a fetch and
  // pushes every delivered word into the scoreboard queue
  logic [15:0] nxt = 16'h0101;
  always @(posedge clk) begin
    if (!rst_n) begin
      buf_vld  <= 1'b0;
      buf_data <= 16'h0;
    end else begin
      buf_vld <= buf_rd;
      if (buf_rd) begin
        buf_data <= nxt;
        exp_q.push_back(nxt);
        nxt <= nxt + 16'h0137;
      end
    end
  end

  // monitor
  int cyc = 0, pos = 0, de_len = 0, req_n = 0, pop_n = 0, de_lines = 0;
  int hs_t = 0, vs_t = 0, hs_w = 0, vs_w = 0, lines_seen = 0;
  bit hs_seen = 0, vs_seen = 0, vs_pend = 0;
  logic hs_q = 0, vs_q = 0, de_q = 0;
  logic [15:0] last_px = 16'h0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      cyc++;
      if (buf_rd) pop_n++;

      if (hsync && !hs_q) begin
        if (hs_seen) chk(cyc - hs_t == HT, "R2", "hsync period", cyc - hs_t, HT);
        hs_t = cyc; hs_seen = 1; hs_w = 0;
      end
      if (hsync) hs_w++;
      if (!hsync && hs_q) chk(hs_w == HSW, "R2", "hsync width", hs_w, HSW);

      if (vsync && !vs_q) begin
        if (vs_seen) chk(cyc - vs_t == HT * VT, "R3", "vsync period", cyc - vs_t, HT * VT);
        chk(de_lines == DE_LINES, "R4", "shown lines per frame", de_lines, DE_LINES);
        vs_t = cyc; vs_seen = 1; vs_w = 0; vs_pend = 1; de_lines = 0;
      end
      if (vsync) vs_w++;
      if (!vsync && vs_q) chk(vs_w == VSW * HT, "R3", "vsync width", vs_w, VSW * HT);

      if (de && !de_q) begin
        if (hs_seen) chk(cyc - hs_t == HS_TO_DE, "R4", "hsync to de", cyc - hs_t, HS_TO_DE);
        if (vs_pend) begin
          chk(cyc - vs_t == VS_TO_DE, "R4", "vsync to first de", cyc - vs_t, VS_TO_DE);
          vs_pend = 0;
        end
        pos = 0; de_len = 0; req_n = 0; de_lines++;
      end

      if (de) begin
        logic [15:0] e;
        if (pos % DUPP == DUPP - 1) begin
          e = last_px;
          chk(pix == e, "R6", "repeated pixel", int'(pix), int'(e));
        end else if (exp_q.size() == 0) begin
          e = pix;
          chk(1'b0, "R7", "fetched word missing", int'(pix), -1);
        end else begin
          e = exp_q.pop_front();
          chk(pix == e, "R7", "fetched pixel order", int'(pix), int'(e));
        end
        last_px = e;
        if (refill_req) begin
          req_n++;
          chk(pos == RQA || pos == RQB, "R8", "refill position", pos, RQA);
        end
        pos++; de_len++;
      end else begin
        chk(pix == BLK, "R9", "black outside de", int'(pix), int'(BLK));
        chk(!refill_req, "R8", "refill outside de", int'(refill_req), 0);
      end

      if (!de && de_q) begin
        chk(de_len == WIN_LEN, "R4", "de length", de_len, WIN_LEN);
        chk(req_n == 2, "R8", "refills per line", req_n, 2);
        chk(pop_n == POPS_LINE, "R5", "fetches per line", pop_n, POPS_LINE);
        pop_n = 0; lines_seen++;
      end

      hs_q = hsync; vs_q = vsync; de_q = de;
    end
  end

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: outputs idle while reset is held
    chk(!hsync && !vsync && !de, "R1", "syncs/de in reset", {hsync, vsync, de}, 0);
    chk(!refill_req && !buf_rd, "R1", "req/fetch in reset", {refill_req, buf_rd}, 0);
    chk(pix == BLK, "R1", "pixel in reset", int'(pix), int'(BLK));
    rst_n = 1'b1;
    repeat (3 * HT * VT + 2 * HT) @(posedge clk);
    @(negedge clk);
    chk(lines_seen >= 3 * DE_LINES, "R4", "windowed lines observed", lines_seen, 3 * DE_LINES);
    if (!done) begin
      done = 1'b1;
      finish_run();
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
    end
  end

endmodule